// File: doc/BRIEF.md
# Serial 010 Detector with Permanent 100 Lockout

This block watches a single-bit serial stream, sampled one bit per rising clock edge, and raises a flag whenever the three most recent bits are 0, 1, 0 in that order. Matches may overlap: the last 0 of one match can serve as the first 0 of the next.

The flag is only live until the first time the stream contains 1, 0, 0. After that, the block enters a lock state it cannot leave until reset, and the flag stays low whatever arrives.

The design is a Moore machine. It has seven states held in a three-bit binary register. The flag is decoded from the state alone. Reset is asserted asynchronously with an active-low pin and released through a two-stage synchronizer.

Top module: `lockout_seq_detector`

## Requirements
- R1: While `rst_n` is low, `match_out` is 0. Driving `rst_n` low forces `match_out` to 0 at once, without waiting for a clock edge.
- R2: After `rst_n` rises, the first input bit is sampled on the third rising edge, with default `SYNC_STAGES`=2. The history at that point is empty: bits seen before or during reset count for nothing.
- R3: `match_out` is 1 for the clock cycle that follows the edge sampling a bit that completes 0,1,0, provided 1,0,0 has not yet been sampled since reset. Otherwise `match_out` is 0.
- R4: Overlapping matches are found: the stream 0,1,0,1,0 raises `match_out` after the third and after the fifth bit.
- R5: `match_out` is never 1 in two consecutive cycles.
- R6: Once 1,0,0 has been sampled, `match_out` stays 0 for every later bit until reset. This holds even when the 1,0,0 completes directly after a match, as in 0,1,0,0.
- R7: Leading runs do not disturb detection: 0,0,0,1,0 and 1,1,0,1,0 each raise `match_out` after the fifth bit, while 0,1,1,0 raises nothing.
- R8: `match_out` depends only on the state. Changing `serial_in` between clock edges leaves `match_out` unchanged.
- R9: A reset clears the lock, so 0,1,0 sent after reset raises `match_out` again.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Rising-edge clock |
| rst_n | input | 1 | Active-low reset, asynchronous assertion, synchronized release |
| serial_in | input | 1 | Serial data, one bit per clock |
| match_out | output | 1 | High for one cycle after a 010 match while not locked |

## Verification
Every internal state shows at the port within three sampled bits, so the bench follows each bit with an expected flag value.

A state that wrongly believes it is locked shows up as a missing pulse on the next 0,1,0. A lock that is lost shows up as a spurious pulse within three bits. A wrong reset origin or a wrong release edge shows on the first two or three bits after reset, for example a false match on 1,0 when there was no leading 0.

// File: rtl/lsd_pkg.sv
package lsd_pkg;
  localparam int STATE_W = 3;

  // Binary encoding; value 7 is unused
  typedef enum logic [STATE_W-1:0] {
    ST_IDLE = 3'd0,  // nothing sampled since reset
    ST_ZRUN = 3'd1,  // tail of zeros, no one yet
    ST_T01  = 3'd2,  // tail 01
    ST_HIT  = 3'd3,  // tail 010, flag high
    ST_ORUN = 3'd4,  // tail of ones
    ST_T10  = 3'd5,  // tail 10
    ST_LOCK = 3'd6   // 100 seen, absorbing
  } state_e;
endpackage

// File: rtl/lsd_rst_sync.sv
module lsd_rst_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  output logic rst_sync_n
);
  logic [STAGES-1:0] chain_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) chain_q <= '0;
    else        chain_q <= {chain_q[STAGES-2:0], 1'b1};
  end

  assign rst_sync_n = chain_q[STAGES-1];

  // R1: reset assertion reaches the synchronized output without a clock
  a_r1_async_assert: assert property (@(posedge clk) !rst_n |-> !rst_sync_n);
endmodule

// File: rtl/lsd_next_state.sv
module lsd_next_state
  import lsd_pkg::*;
(
  input  state_e cur_state,
  input  logic   bit_in,
  output state_e nxt_state
);
  always_comb begin
    nxt_state = ST_IDLE;
    unique case (cur_state)
      ST_IDLE: nxt_state = bit_in ? ST_ORUN : ST_ZRUN;
      ST_ZRUN: nxt_state = bit_in ? ST_T01  : ST_ZRUN;
      ST_T01:  nxt_state = bit_in ? ST_ORUN : ST_HIT;
      ST_HIT:  nxt_state = bit_in ? ST_T01  : ST_LOCK;
      ST_ORUN: nxt_state = bit_in ? ST_ORUN : ST_T10;
      ST_T10:  nxt_state = bit_in ? ST_T01  : ST_LOCK;
      ST_LOCK: nxt_state = ST_LOCK;
      default: nxt_state = ST_IDLE;
    endcase
  end
endmodule

// File: rtl/lsd_state_reg.sv
module lsd_state_reg
  import lsd_pkg::*;
(
  input  logic   clk,
  input  logic   rst_sync_n,
  input  state_e d_state,
  output state_e q_state
);
  always_ff @(posedge clk or negedge rst_sync_n) begin
    if (!rst_sync_n) q_state <= ST_IDLE;
    else             q_state <= d_state;
  end

  // R6: the lock state is never left while reset is released
  a_r6_lock_sticky: assert property (@(posedge clk) disable iff (!rst_sync_n)
    (q_state == ST_LOCK) |=> (q_state == ST_LOCK));

  // Only the seven encoded values ever appear
  a_r2_legal_code: assert property (@(posedge clk) disable iff (!rst_sync_n)
    q_state != 3'd7);
endmodule

// File: rtl/lockout_seq_detector.sv
module lockout_seq_detector #(
  parameter int SYNC_STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic serial_in,
  output logic match_out
);
  import lsd_pkg::*;

  logic   rst_sync_n;
  state_e state_q;
  state_e state_d;

  lsd_rst_sync #(.STAGES(SYNC_STAGES)) u_rst_sync (
    .clk        (clk),
    .rst_n      (rst_n),
    .rst_sync_n (rst_sync_n)
  );

  lsd_next_state u_next (
    .cur_state (state_q),
    .bit_in    (serial_in),
    .nxt_state (state_d)
  );

  lsd_state_reg u_reg (
    .clk        (clk),
    .rst_sync_n (rst_sync_n),
    .d_state    (state_d),
    .q_state    (state_q)
  );

  // Moore output decode
  assign match_out = (state_q == ST_HIT);

  // R1: flag low whenever reset pin is low
  a_r1_reset_quiet: assert property (@(posedge clk) !rst_n |-> !match_out);

  // R3: a raised flag follows sampled bits 1 then 0
  a_r3_tail_bits: assert property (@(posedge clk) disable iff (!rst_sync_n)
    match_out |-> (!$past(serial_in) && $past(serial_in, 2)));

  // R5: never two flag cycles in a row
  a_r5_single_pulse: assert property (@(posedge clk) disable iff (!rst_sync_n)
    match_out |=> !match_out);

  // R4: a 1 after a match keeps the 01 tail for overlap
  a_r4_overlap_tail: assert property (@(posedge clk) disable iff (!rst_sync_n)
    (match_out && serial_in) |=> (state_q == ST_T01));

  // R6: a 0 after a match locks the machine
  a_r6_lock_after_hit: assert property (@(posedge clk) disable iff (!rst_sync_n)
    (match_out && !serial_in) |=> (state_q == ST_LOCK));
endmodule

// File: tb/lockout_seq_detector_tb.sv
module lockout_seq_detector_tb;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic serial_in = 1'b0;
  logic match_out;

  typedef struct {
    logic  exp;
    string tag;
  } item_t;

  item_t    sb_q[$];
  int       total = 0;
  int       bad = 0;
  logic [2:0] hist = 3'b000;
  int       nbits = 0;
  bit       seen100 = 1'b0;
  bit       mon_on = 1'b0;

  always #4 clk = ~clk;  // 125 MHz

  lockout_seq_detector u_dut (
    .clk       (clk),
    .rst_n     (rst_n),
    .serial_in (serial_in),
    .match_out (match_out)
  );

  task automatic check(input logic act, input logic exp, input string tag);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s actual=%b expected=%b at %0t", tag, act, exp, $time);
    end
  endtask

  // Reset, then wait the two release edges (R2) before any bit
  task automatic do_reset();
    @(negedge clk);
    rst_n = 1'b0;
    serial_in = 1'b0;
    mon_on = 1'b0;
    sb_q.delete();
    hist = 3'b000;
    nbits = 0;
    seen100 = 1'b0;
    #1 check(match_out, 1'b0, "R1 reset low");
    repeat (2) @(negedge clk);
    check(match_out, 1'b0, "R1 reset held");
    rst_n = 1'b1;
    @(posedge clk);
    @(posedge clk);
    mon_on = 1'b1;
  endtask

  // Driver: push expectation derived from the requirements
  task automatic send_bit(input logic b, input string tag);
    logic e;
    @(negedge clk);
    serial_in = b;
    hist = {hist[1:0], b};
    nbits++;
    if (nbits >= 3 && hist == 3'b100) seen100 = 1'b1;
    e = (nbits >= 3) && (hist == 3'b010) && !seen100;
    sb_q.push_back('{exp: e, tag: tag});
  endtask

  task automatic send_seq(input logic [15:0] bits, input int n, input string tag);
    for (int i = n - 1; i >= 0; i--) send_bit(bits[i], tag);
  endtask

  task automatic drain();
    repeat (2) @(negedge clk);
  endtask

  // Monitor: compare after each edge, away from it
  initial begin
    forever begin
      @(posedge clk);
      #2;
      if (mon_on && sb_q.size() > 0) begin
        item_t it;
        it = sb_q.pop_front();
        check(match_out, it.exp, it.tag);
      end
    end
  end

  initial begin
    #(200000 * 8);
    total++;
    bad++;
    $display("FAIL watchdog expired actual=hung expected=done");
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    #3;
    check(match_out, 1'b0, "R1 initial reset");
    do_reset();
    // R2: bits right after release form a match
    send_seq(16'b010, 3, "R2 first bits");
    drain();
    do_reset();
    // R2: no stale zero before the first bit
    send_seq(16'b10, 2, "R2 empty history");
    drain();

    do_reset();
    send_seq(16'b1010, 4, "R3 basic match");
    drain();

    do_reset();
    send_seq(16'b01010, 5, "R4 overlap");
    drain();

    do_reset();
    send_seq(16'b00010, 5, "R7 zero run");
    drain();
    do_reset();
    send_seq(16'b11010, 5, "R7 one run");
    drain();
    do_reset();
    send_seq(16'b0110, 4, "R7 no match");
    drain();

    // R5 and R6: match then 0 locks
    do_reset();
    send_seq(16'b0100, 4, "R5 pulse then lock");
    send_seq(16'b1010101, 7, "R6 locked after hit");
    drain();
    do_reset();
    send_seq(16'b100, 3, "R6 lock");
    send_seq(16'b0101010, 7, "R6 stays locked");
    drain();

    // R9: reset clears the lock
    do_reset();
    send_seq(16'b010, 3, "R9 after unlock");
    drain();

    // R8: input wiggle between edges leaves the flag alone
    do_reset();
    send_seq(16'b010, 3, "R8 setup");
    @(posedge clk);
    #1 serial_in = 1'b1;
    #1 check(match_out, 1'b1, "R8 moore hold");
    serial_in = 1'b0;
    #1 check(match_out, 1'b1, "R8 moore hold");
    // R1: asynchronous assertion drops the flag mid-cycle
    rst_n = 1'b0;
    #1 check(match_out, 1'b0, "R1 async assert");
    mon_on = 1'b0;
    sb_q.delete();
    do_reset();
    send_seq(16'b010, 3, "R9 post async reset");
    drain();

    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule